// File: doc/BRIEF.md
# Unaligned Load/Store Splitting Adapter

This block sits between the load/store port of a processor and a memory bus that is 32 bits wide and only accepts word-aligned beats. It takes one request at a time. A request carries a byte address, an access size, a read/write direction and write data. The adapter turns the request into one or two aligned bus beats, each with its own byte-lane enables. On a read, it gathers the wanted bytes from each beat and returns them as a single right-justified value.

Each response also says whether the access was single-copy atomic. An access that crosses a word boundary reaches memory as two separate beats, so another bus observer could see it half done. Even a misaligned access that fits in one beat is outside the atomic set. When unaligned trapping is switched on, a misaligned request gets a fault response and never reaches the bus.

Top module: `ua_split_adapter`

## Requirements
- R1: The size code is 0 for a byte, 1 for a halfword and 2 for a word. Code 3 is handled as a word. An access whose bytes all sit in one aligned word is sent as exactly one beat at the address with bits 1:0 cleared. Byte lane k (bits 8k+7:8k) is enabled when address offset k is touched. This gives 0001, 0010, 0100 or 1000 for a byte, 0011 or 1100 for an even halfword, 0110 for a halfword at offset 1, and 1111 for an aligned word.
- R2: A halfword at offset 3, or a word at offset 1, 2 or 3, is sent as two beats. The first beat goes to the aligned base address with lanes offset..3 enabled. The second goes to base+4 with the remaining low lanes enabled, for example 1100 then 0011 for a word at offset 2.
- R3: On a write, byte i of the request data (i below the access length) is driven on lane (offset+i) mod 4 of the beat that holds address offset+i. Lanes that are not enabled drive zero, and request data bytes above the access length are dropped.
- R4: On a read, result byte i is taken from lane (offset+i) mod 4 of the beat that holds it. Result bits above the access length are zero. Read data on lanes that are not enabled has no effect on the result.
- R5: rsp_nonatomic is 1 on a response exactly when the request was not a byte, an even-address halfword or a word at offset 0. rsp_nonatomic, rsp_err and rsp_fault are 0 whenever rsp_valid is 0.
- R6: While trap_en is 1, a request whose address is not naturally aligned for its size is answered, in the cycle after it is accepted, with rsp_fault=1 and rsp_rdata=0. No bus beat is issued for it.
- R7: req_ready is 1 only while no request is in progress. While bus_valid is 1 and bus_ready is 0, the beat address, lane enables and write data hold steady. The lower-address beat is always issued first.
- R8: If bus_err is 1 on any accepted beat, the response follows in the next cycle with rsp_err=1 and rsp_rdata=0, and no further beat of that request is issued.
- R9: After reset, bus_valid and rsp_valid are 0 and req_ready is 1. rsp_valid is a one-cycle pulse. rsp_rdata is 0 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_en | input | 1 | Fault on misaligned requests instead of splitting them |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Adapter can accept a request |
| req_addr | input | AW | Byte address of the request |
| req_size | input | 2 | Access size code (0 byte, 1 halfword, 2/3 word) |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_wdata | input | 32 | Store data, right-justified |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Merged, right-justified load data |
| rsp_err | output | 1 | A bus beat returned an error |
| rsp_fault | output | 1 | Misaligned request trapped |
| rsp_nonatomic | output | 1 | Access was not single-copy atomic |
| bus_valid | output | 1 | Aligned beat present |
| bus_ready | input | 1 | Bus accepts the beat (read data and error valid with it) |
| bus_addr | output | AW | Word-aligned beat address |
| bus_write | output | 1 | Beat direction |
| bus_be | output | 4 | Byte-lane enables of the beat |
| bus_wdata | output | 32 | Lane-steered store data |
| bus_rdata | input | 32 | Beat read data |
| bus_err | input | 1 | Beat error response |

## Verification
The bench sweeps every size code, all four address offsets, both directions and both settings of the trap enable, each with zero-wait and one-wait-state bus responses. This separates single-beat cases from split cases, the odd halfword that fits in one word from the one that crosses, and held beats from immediate ones. The bus model fills every disabled lane with a marker byte and fills enabled lanes with an address-derived pattern. A wrong lane choice in the merge, or leakage from an unused lane, therefore changes the result. Error injection on the first and on the second beat of split and unsplit requests shows that a remaining beat is dropped and the response carries the error.

// File: rtl/ua_split_pkg.sv
package ua_split_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned DW    = 8 * LANES;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BEAT0 = 2'd1,
    ST_BEAT1 = 2'd2,
    ST_RESP  = 2'd3
  } ua_state_t;

  // number of bytes touched by a size code (code 3 is taken as a word)
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // mask keeping only the bytes of the access, right-justified
  function automatic logic [DW-1:0] keep_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // lanes touched across two adjacent words, bit k = byte offset k
  function automatic logic [2*LANES-1:0] lane_span(input logic [1:0] off,
                                                    input logic [1:0] sz);
    logic [2*LANES-1:0] base_m;
    base_m = (8'd1 << size_bytes(sz)) - 8'd1;
    return base_m << off;
  endfunction

  // single-copy atomic set: bytes, even halfwords, aligned words
  function automatic logic is_natural(input logic [1:0] off,
                                      input logic [1:0] sz);
    return (sz == 2'd0) || ((sz == 2'd1) && !off[0]) || (off == 2'd0);
  endfunction
endpackage

// File: rtl/ua_lane_plan.sv
module ua_lane_plan
  import ua_split_pkg::*;
(
  input  logic [1:0]       off,
  input  logic [1:0]       size,
  output logic [LANES-1:0] be_lo,
  output logic [LANES-1:0] be_hi,
  output logic             split,
  output logic             natural
);
  logic [2*LANES-1:0] span;

  always_comb begin
    span    = lane_span(off, size);
    be_lo   = span[LANES-1:0];
    be_hi   = span[2*LANES-1:LANES];
    split   = |be_hi;
    natural = is_natural(off, size);
  end
endmodule

// File: rtl/ua_wdata_steer.sv
module ua_wdata_steer
  import ua_split_pkg::*;
(
  input  logic [1:0]    off,
  input  logic [1:0]    size,
  input  logic [DW-1:0] wdata,
  input  logic          hi_sel,
  output logic [DW-1:0] beat_wdata
);
  logic [DW-1:0]   kept;
  logic [2*DW-1:0] wide;

  always_comb begin
    kept       = wdata & keep_mask(size);
    wide       = {{DW{1'b0}}, kept} << {off, 3'b000};
    beat_wdata = hi_sel ? wide[2*DW-1:DW] : wide[DW-1:0];
  end
endmodule

// File: rtl/ua_rdata_merge.sv
module ua_rdata_merge
  import ua_split_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cap_lo,
  input  logic             cap_hi,
  input  logic [LANES-1:0] be_lo,
  input  logic [LANES-1:0] be_hi,
  input  logic [DW-1:0]    bus_rdata,
  input  logic [1:0]       off,
  input  logic [1:0]       size,
  output logic [DW-1:0]    merged
);
  logic [2*DW-1:0] gather_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gather_q[8*k +: 8]      <= 8'h00;
        gather_q[DW+8*k +: 8]   <= 8'h00;
      end else if (clear) begin
        gather_q[8*k +: 8]      <= 8'h00;
        gather_q[DW+8*k +: 8]   <= 8'h00;
      end else begin
        if (cap_lo && be_lo[k]) gather_q[8*k +: 8]    <= bus_rdata[8*k +: 8];
        if (cap_hi && be_hi[k]) gather_q[DW+8*k +: 8] <= bus_rdata[8*k +: 8];
      end
    end
  end

  logic [2*DW-1:0] shifted;
  always_comb begin
    shifted = gather_q >> {off, 3'b000};
    merged  = shifted[DW-1:0] & keep_mask(size);
  end
endmodule

// File: rtl/ua_split_adapter.sv
module ua_split_adapter
  import ua_split_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_err,
  output logic             rsp_fault,
  output logic             rsp_nonatomic,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_write,
  output logic [LANES-1:0] bus_be,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_err
);
  ua_state_t     state_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    size_q;
  logic          write_q;
  logic [DW-1:0] wdata_q;
  logic          fault_q;
  logic          err_q;

  // named internal events
  logic req_fire;
  logic beat_fire;
  logic hi_beat;
  logic req_trap;
  logic cap_lo;
  logic cap_hi;

  logic [LANES-1:0] be_lo, be_hi;
  logic             split, natural;
  logic [DW-1:0]    merged;
  logic [AW-1:0]    base_addr;

  ua_lane_plan u_plan (
    .off     (addr_q[1:0]),
    .size    (size_q),
    .be_lo   (be_lo),
    .be_hi   (be_hi),
    .split   (split),
    .natural (natural)
  );

  ua_wdata_steer u_steer (
    .off        (addr_q[1:0]),
    .size       (size_q),
    .wdata      (wdata_q),
    .hi_sel     (hi_beat),
    .beat_wdata (bus_wdata)
  );

  ua_rdata_merge u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (req_fire),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .be_lo     (be_lo),
    .be_hi     (be_hi),
    .bus_rdata (bus_rdata),
    .off       (addr_q[1:0]),
    .size      (size_q),
    .merged    (merged)
  );

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    req_fire  = req_valid && req_ready;
    req_trap  = trap_en && !is_natural(req_addr[1:0], req_size);
    bus_valid = (state_q == ST_BEAT0) || (state_q == ST_BEAT1);
    hi_beat   = (state_q == ST_BEAT1);
    beat_fire = bus_valid && bus_ready;
    cap_lo    = beat_fire && !hi_beat && !bus_err;
    cap_hi    = beat_fire && hi_beat && !bus_err;
    base_addr = {addr_q[AW-1:2], 2'b00};
    bus_addr  = hi_beat ? base_addr + AW'(LANES) : base_addr;
    bus_be    = hi_beat ? be_hi : be_lo;
    bus_write = write_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= 2'd0;
      write_q <= 1'b0;
      wdata_q <= '0;
      fault_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_fire) begin
            addr_q  <= req_addr;
            size_q  <= req_size;
            write_q <= req_write;
            wdata_q <= req_wdata;
            fault_q <= req_trap;
            err_q   <= 1'b0;
            state_q <= req_trap ? ST_RESP : ST_BEAT0;
          end
        end
        ST_BEAT0: begin
          if (beat_fire) begin
            if (bus_err) begin
              err_q   <= 1'b1;
              state_q <= ST_RESP;
            end else begin
              state_q <= split ? ST_BEAT1 : ST_RESP;
            end
          end
        end
        ST_BEAT1: begin
          if (beat_fire) begin
            err_q   <= bus_err;
            state_q <= ST_RESP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rsp_valid     = (state_q == ST_RESP);
    rsp_fault     = rsp_valid && fault_q;
    rsp_err       = rsp_valid && err_q;
    rsp_nonatomic = rsp_valid && !natural;
    rsp_rdata     = (rsp_valid && !write_q && !fault_q && !err_q) ? merged : '0;
  end
endmodule

// File: rtl/ua_split_chk.sv
module ua_split_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trap_en,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic          rsp_fault,
  input logic          rsp_nonatomic,
  input logic          bus_valid,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic          bus_write,
  input logic [3:0]    bus_be,
  input logic [31:0]   bus_wdata,
  input logic          bus_err
);
  function automatic logic misaligned(input logic [1:0] a, input logic [1:0] sz);
    return ((sz == 2'd1) && a[0]) || ((sz >= 2'd2) && (a != 2'd0));
  endfunction

  function automatic logic [31:0] lane_bits(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_be) && $stable(bus_wdata)); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready); // R7
  AST_BEAT_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_be != 4'b0000) && (bus_addr[1:0] == 2'b00)); // R1
  AST_SECOND_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_err |=> !bus_valid || (bus_addr == AW'($past(bus_addr) + AW'(4)))); // R2
  AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write |-> (bus_wdata & ~lane_bits(bus_be)) == 32'h0); // R3
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_err && !rsp_fault && !rsp_nonatomic); // R5
  AST_TRAP_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && trap_en && misaligned(req_addr[1:0], req_size)
    |=> !bus_valid && rsp_valid && rsp_fault); // R6
  AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_err |=> !bus_valid && rsp_valid && rsp_err); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
endmodule

bind ua_split_adapter ua_split_chk #(.AW(AW)) chk_i (.*);

// File: tb/ua_split_adapter_tb_top.sv
`timescale 1ns/1ps
module ua_split_adapter_tb_top;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          trap_en = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd0;
  logic          req_write = 1'b0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic          rsp_err, rsp_fault, rsp_nonatomic;
  logic          bus_valid;
  logic          bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic          bus_write;
  logic [3:0]    bus_be;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata = '0;
  logic          bus_err = 1'b0;

  ua_split_adapter #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .trap_en(trap_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rsp_fault(rsp_fault), .rsp_nonatomic(rsp_nonatomic),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory pattern: one byte per (word address, lane)
  function automatic logic [7:0] mem_byte(input logic [31:0] waddr, input int lane);
    return 8'(int'(waddr[9:2]) * 7 + lane * 31 + 8'h3C);
  endfunction

  // bus model
  int          wait_cfg = 0;
  int          err_cfg = 0;
  int          stall = 0;
  int          beat_cnt = 0;
  logic [31:0] seen_addr [4];
  logic [3:0]  seen_be   [4];
  logic [31:0] seen_wd   [4];
  logic        seen_wr   [4];

  always @(negedge clk) begin
    if (bus_valid) begin
      if (stall >= wait_cfg) begin
        bus_ready = 1'b1;
        if (beat_cnt < 4) begin
          seen_addr[beat_cnt] = bus_addr;
          seen_be[beat_cnt]   = bus_be;
          seen_wd[beat_cnt]   = bus_wdata;
          seen_wr[beat_cnt]   = bus_write;
        end
        bus_err = (beat_cnt + 1 == err_cfg);
        for (int l = 0; l < 4; l++)
          bus_rdata[8*l +: 8] = bus_be[l] ? mem_byte(bus_addr, l) : 8'hEE;
        beat_cnt++;
        stall = 0;
      end else begin
        bus_ready = 1'b0;
        bus_err = 1'b0;
        bus_rdata = 32'hEEEE_EEEE;
        stall++;
      end
    end else begin
      bus_ready = 1'b0;
      bus_err = 1'b0;
      stall = 0;
    end
  end

  task automatic do_access(input logic [31:0] addr, input logic [1:0] sz, input bit wr,
                           input logic [31:0] wd, input bit trap, input int wt, input int errat);
    int nb, off, nbeats, exp_beats, n;
    bit nat, exp_fault, exp_err;
    logic [3:0]  exp_be [2];
    logic [31:0] exp_wd [2];
    logic [31:0] exp_ad [2];
    logic [31:0] exp_rd, exp_rdata;
    nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    off = int'(addr[1:0]);
    nat = (nb == 1) || (nb == 2 && off % 2 == 0) || (off == 0);
    exp_ad[0] = {addr[31:2], 2'b00};
    exp_ad[1] = exp_ad[0] + 32'd4;
    exp_be[0] = 4'b0; exp_be[1] = 4'b0; exp_wd[0] = 32'h0; exp_wd[1] = 32'h0; exp_rd = 32'h0;
    for (int i = 0; i < nb; i++) begin
      int p, b, l;
      p = off + i; b = p / 4; l = p % 4;
      exp_be[b][l] = 1'b1;
      exp_wd[b][8*l +: 8] = wd[8*i +: 8];
      exp_rd[8*i +: 8] = mem_byte(exp_ad[b], l);
    end
    nbeats    = (off + nb > 4) ? 2 : 1;
    exp_fault = trap && !nat;
    exp_err   = !exp_fault && ((errat == 1) || (errat == 2 && nbeats == 2));
    exp_beats = exp_fault ? 0 : (errat == 1) ? 1 : nbeats;
    exp_rdata = (wr || exp_fault || exp_err) ? 32'h0 : exp_rd;

    @(negedge clk);
    wait_cfg = wt; err_cfg = errat; beat_cnt = 0;
    trap_en = trap; req_addr = addr; req_size = sz; req_write = wr; req_wdata = wd;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R7 ready while idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R7 ready low while busy", 32'(req_ready), 32'd0);
    n = 0;
    while (!rsp_valid && n < 30) begin @(negedge clk); n++; end
    chk(rsp_valid == 1'b1, "R9 response seen", 32'(rsp_valid), 32'd1);
    if (exp_fault)
      chk(n == 0, "R6 fault in cycle after accept", 32'(n), 32'd0);
    chk(beat_cnt == exp_beats, exp_fault ? "R6 no beat on fault" :
        (exp_err ? "R8 beats on error" : (nbeats == 2 ? "R2 beat count" : "R1 beat count")),
        32'(beat_cnt), 32'(exp_beats));
    for (int b = 0; b < exp_beats && b < beat_cnt; b++) begin
      chk(seen_addr[b] == exp_ad[b], b == 0 ? "R7 first beat low address" : "R2 second beat address",
          seen_addr[b], exp_ad[b]);
      chk(seen_be[b] == exp_be[b], nbeats == 2 ? "R2 lane enables" : "R1 lane enables",
          32'(seen_be[b]), 32'(exp_be[b]));
      chk(seen_wr[b] == wr, "R3 beat direction", 32'(seen_wr[b]), 32'(wr));
      if (wr) chk(seen_wd[b] == exp_wd[b], "R3 write lane data", seen_wd[b], exp_wd[b]);
    end
    chk(rsp_rdata == exp_rdata, exp_fault ? "R6 fault data" : (exp_err ? "R8 error data" :
        (wr ? "R9 write data zero" : "R4 merged read")), rsp_rdata, exp_rdata);
    chk(rsp_err == exp_err, "R8 error flag", 32'(rsp_err), 32'(exp_err));
    chk(rsp_fault == exp_fault, "R6 fault flag", 32'(rsp_fault), 32'(exp_fault));
    chk(rsp_nonatomic == !nat, "R5 nonatomic flag", 32'(rsp_nonatomic), 32'(!nat));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 response pulse", 32'(rsp_valid), 32'd0);
    chk(rsp_nonatomic == 1'b0 && rsp_err == 1'b0 && rsp_fault == 1'b0, "R5 flags quiet",
        {29'd0, rsp_nonatomic, rsp_err, rsp_fault}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_valid == 1'b0, "R9 reset bus_valid", 32'(bus_valid), 32'd0);
    chk(rsp_valid == 1'b0, "R9 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R9 reset req_ready", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int tr = 0; tr < 2; tr++)
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int wr = 0; wr < 2; wr++)
            for (int wt = 0; wt < 2; wt++) begin
              logic [31:0] a;
              a = 32'h0000_0400 + 32'(sz * 64 + wt * 32 + wr * 8 + off);
              do_access(a, 2'(sz), wr[0], 32'h8C3E_5A71 ^ {4{a[7:0]}}, tr[0], wt, 0);
            end
    // bus error injection
    do_access(32'h0000_0812, 2'd2, 1'b0, 32'h0, 1'b0, 0, 1);
    do_access(32'h0000_0812, 2'd2, 1'b0, 32'h0, 1'b0, 1, 2);
    do_access(32'h0000_0820, 2'd2, 1'b1, 32'h1234_5678, 1'b0, 0, 1);
    do_access(32'h0000_0833, 2'd1, 1'b0, 32'h0, 1'b0, 1, 2);
    do_access(32'h0000_0841, 2'd1, 1'b0, 32'h0, 1'b0, 0, 2);
    do_access(32'h0000_0857, 2'd1, 1'b1, 32'hFFFF_A5C3, 1'b0, 1, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule